// File: doc/BRIEF.md
# Timer Channel: Capture, Compare and PWM

One channel of a general-purpose timer. The channel does not own a counter. It watches a shared free-running count value and the one-cycle pulse that marks the count's wrap. The channel has two addressable registers: a control/status word and a channel value register. Writing the control word picks how the channel behaves. In capture mode the channel records the count when a chosen edge arrives on its input pin. In output compare mode, plain or double-buffered, it sets, clears or toggles its output level when the count equals the channel value. It can also toggle its output at every wrap, and it can hold the output at full duty.

A PWM waveform comes from combining two settings: clear on match, and toggle on wrap. The full-duty override only applies while toggle-on-wrap is set. It is taken in only when the count wraps, so the period in which it is written plays out normally. Buffered mode also defers new channel values to the next wrap, so a period is never cut short by a rewrite.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control word and channel value read as 0, the flag is 0, the output enable is low and the output level is high.
- R2: Address 0 is the control/status word: bit 7 flag, bit 6 reads 0, bits 5:4 mode select, bits 3:2 edge/action select, bit 1 toggle-on-wrap, bit 0 full-duty request. Address 1 holds the channel value. A write lands at the clock edge and reads are combinational. A write to address 0 never sets the flag.
- R3: With edge/action select 00 the output enable is low, and from the next edge the output level is high when mode bit 4 is 0 and low when it is 1.
- R4: Mode 00 with a nonzero edge select is capture. Select 01 is rising edge only, 10 falling only, 11 either. The pin goes through two synchronizing flops, so a pin change applied while the count is c stores count c+2 (modulo the period) in the channel value.
- R5: A capture or an output match sets the flag. The flag clears only when address 0 is written with bit 7 at 0 and the previous access to address 0 was a read that saw the flag at 1. A clearing write with no such read leaves the flag set.
- R6: Modes 01, 10 and 11 with a nonzero select drive the output (enable high). On a count match, select 01 toggles the level, 10 clears it and 11 sets it, effective at the next edge.
- R7: In mode 01 the match uses the channel value directly. In modes 1x it uses a shadow copy that is reloaded from the channel value at each wrap, so a rewrite only takes effect in the period after the next wrap.
- R8: With toggle-on-wrap set in an output mode the level toggles at each wrap. In capture mode the bit has no effect on the output level.
- R9: When a wrap and a match fall in the same cycle with toggle-on-wrap set, only the wrap toggle is applied.
- R10: The full-duty request, ANDed with toggle-on-wrap, is sampled only at a wrap. While the sampled value is active the level is held high and matches do not change it. Setting it or clearing it therefore shows from the period after the one it is written in.
- R11: With toggle-on-wrap clear, the full-duty request has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | CNT_W | Shared free-running count |
| cntOvf | input | 1 | High in the cycle the count wraps |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (arms flag clear) |
| busAddr | input | 1 | 0 = control/status, 1 = channel value |
| busWrData | input | CNT_W | Write data |
| busRdData | output | CNT_W | Read data for busAddr |
| pinIn | input | 1 | Asynchronous capture input |
| pinOut | output | 1 | Output level |
| pinOutEn | output | 1 | High when the timer drives the pin |

## Verification
Most faults in the internal state reach the output level within one count period. A wrong shadow value, or a full-duty latch sampled at the wrong moment, moves the low-time of a PWM period. A dropped or doubled toggle at a wrap inverts every later period, and this shows at the first wrap. A synchronizer with the wrong depth shifts every captured count by one. The bench reads back the channel value a few cycles after each pin edge and compares it with count plus two. A flag arming fault shows at the very next clearing write, as a flag that stays set or clears too early.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  localparam int CTRL_W   = 8;
  localparam int FLAG_BIT = 7;

  // edge/action select codes
  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_RISE = 2'b01;  // capture: rising, compare: toggle
  localparam logic [1:0] SEL_FALL = 2'b10;  // capture: falling, compare: clear
  localparam logic [1:0] SEL_BOTH = 2'b11;  // capture: either, compare: set

  typedef struct packed {
    logic [1:0] modeSel;
    logic [1:0] edgeSel;
    logic       ovfToggle;
    logic       maxDuty;
  } ctrlT;

  typedef struct packed {
    logic capture;
    logic loadShadow;
    logic useShadow;
    logic lvlSet;
    logic lvlClr;
    logic lvlTgl;
  } strobeT;

endpackage

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             pinIn,
  input  strobeT           stb,
  input  logic             chanWr,
  input  logic [CNT_W-1:0] chanWrData,
  output logic [CNT_W-1:0] chanQ,
  output logic             eqHit,
  output logic             riseHit,
  output logic             fallHit,
  output logic             levelQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   edgeQ;
  logic [CNT_W-1:0]       shadowQ;
  logic [CNT_W-1:0]       cmpVal;

  // input synchronizer and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      edgeQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      edgeQ <= syncQ[LAST];
    end
  end

  assign riseHit = syncQ[LAST] & ~edgeQ;
  assign fallHit = ~syncQ[LAST] & edgeQ;

  // channel value register: capture wins over a bus write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ <= '0;
    end else if (stb.capture) begin
      chanQ <= cntVal;
    end else if (chanWr) begin
      chanQ <= chanWrData;
    end
  end

  // shadow compare copy, reloaded at wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
    end else if (stb.loadShadow) begin
      shadowQ <= chanQ;
    end
  end

  assign cmpVal = stb.useShadow ? shadowQ : chanQ;
  assign eqHit  = (cntVal == cmpVal);

  // output level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 1'b1;
    end else if (stb.lvlSet) begin
      levelQ <= 1'b1;
    end else if (stb.lvlClr) begin
      levelQ <= 1'b0;
    end else if (stb.lvlTgl) begin
      levelQ <= ~levelQ;
    end
  end

  // R4: a capture stores the count seen in the capture cycle
  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> chanQ == $past(cntVal));

  // R7: the shadow copy moves only after a wrap strobe
  assert_shadow_at_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shadowQ) |-> $past(stb.loadShadow));

  // R8: a toggle strobe flips the level
  assert_toggle_flips_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.lvlTgl |=> levelQ != $past(levelQ));

endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntOvf,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busAddr,
  input  logic       wrFlagBit,
  input  logic [5:0] wrCtrlBits,
  input  logic       eqHit,
  input  logic       riseHit,
  input  logic       fallHit,
  output strobeT     stb,
  output ctrlT       ctrlQ,
  output logic       flagQ,
  output logic       maxActQ,
  output logic       outEn,
  output logic       presetMode
);

  logic armQ;
  logic isCap;
  logic capEvt;
  logic matchHit;
  logic maxNext;
  logic ctrlWr;
  logic flagClr;

  assign ctrlWr     = busWr & ~busAddr;
  assign presetMode = (ctrlQ.edgeSel == SEL_OFF);
  assign isCap      = !presetMode && (ctrlQ.modeSel == 2'b00);
  assign outEn      = !presetMode && (ctrlQ.modeSel != 2'b00);

  always_comb begin
    capEvt = 1'b0;
    if (isCap) begin
      unique case (ctrlQ.edgeSel)
        SEL_RISE: capEvt = riseHit;
        SEL_FALL: capEvt = fallHit;
        SEL_BOTH: capEvt = riseHit | fallHit;
        default:  capEvt = 1'b0;
      endcase
    end
  end

  assign matchHit = outEn & eqHit;
  assign maxNext  = ctrlQ.ovfToggle & ctrlQ.maxDuty & outEn;

  // strobe generation for the datapath
  always_comb begin
    stb            = '0;
    stb.capture    = capEvt;
    stb.loadShadow = cntOvf;
    stb.useShadow  = outEn & ctrlQ.modeSel[1];
    if (presetMode) begin
      if (ctrlQ.modeSel[0]) stb.lvlClr = 1'b1;
      else                  stb.lvlSet = 1'b1;
    end else if (outEn) begin
      if (cntOvf && ctrlQ.ovfToggle) begin
        if (maxActQ || maxNext) stb.lvlSet = 1'b1;
        else                    stb.lvlTgl = 1'b1;
      end else if (maxActQ) begin
        stb.lvlSet = 1'b1;
      end else if (matchHit) begin
        unique case (ctrlQ.edgeSel)
          SEL_RISE: stb.lvlTgl = 1'b1;
          SEL_FALL: stb.lvlClr = 1'b1;
          SEL_BOTH: stb.lvlSet = 1'b1;
          default:  stb.lvlTgl = 1'b0;
        endcase
      end
    end
  end

  // control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= ctrlT'(wrCtrlBits);
    end
  end

  // full-duty latch, sampled only at wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxActQ <= 1'b0;
    end else if (cntOvf) begin
      maxActQ <= maxNext;
    end
  end

  // flag and its read-then-write clear
  assign flagClr = ctrlWr & armQ & ~wrFlagBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      armQ  <= 1'b0;
    end else begin
      if (capEvt || matchHit) flagQ <= 1'b1;
      else if (flagClr)       flagQ <= 1'b0;
      if (ctrlWr)                          armQ <= 1'b0;
      else if (busRd && !busAddr && flagQ) armQ <= 1'b1;
    end
  end

  // R5: the flag only falls after an arming read
  assert_flag_clear_armed_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(armQ));

  // R10: the full-duty latch only moves at a wrap
  assert_max_at_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(maxActQ) |-> $past(cntOvf));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntOvf,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOutEn
);

  strobeT           stb;
  ctrlT             ctrlQ;
  logic             flagQ;
  logic             maxActQ;
  logic             presetMode;
  logic [CNT_W-1:0] chanQ;
  logic             eqHit;
  logic             riseHit;
  logic             fallHit;
  logic             levelQ;
  logic [CNT_W-1:0] statusWord;

  tmr_chan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntOvf     (cntOvf),
    .busWr      (busWr),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .wrFlagBit  (busWrData[FLAG_BIT]),
    .wrCtrlBits (busWrData[5:0]),
    .eqHit      (eqHit),
    .riseHit    (riseHit),
    .fallHit    (fallHit),
    .stb        (stb),
    .ctrlQ      (ctrlQ),
    .flagQ      (flagQ),
    .maxActQ    (maxActQ),
    .outEn      (pinOutEn),
    .presetMode (presetMode)
  );

  tmr_chan_dp #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cntVal     (cntVal),
    .pinIn      (pinIn),
    .stb        (stb),
    .chanWr     (busWr & busAddr),
    .chanWrData (busWrData),
    .chanQ      (chanQ),
    .eqHit      (eqHit),
    .riseHit    (riseHit),
    .fallHit    (fallHit),
    .levelQ     (levelQ)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[FLAG_BIT] = flagQ;
    statusWord[5:0]      = ctrlQ;
  end

  assign busRdData = busAddr ? chanQ : statusWord;
  assign pinOut    = levelQ;

  // R10: an active full-duty latch keeps the output high
  assert_max_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maxActQ && pinOutEn && !cntOvf) |=> pinOut);

  // R3: an undriven channel presets its level from mode bit 4
  assert_preset_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    presetMode |=> pinOut == !$past(ctrlQ.modeSel[0]));

endmodule

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;

  localparam int CW  = 8;
  localparam int TOP = 15;
  localparam int SY  = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic [CW-1:0] cntVal;
  logic          cntOvf;
  logic          busWr, busRd, busAddr;
  logic [CW-1:0] busWrData;
  logic [CW-1:0] busRdData;
  logic          pinIn, pinOut, pinOutEn;

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string curReq  = "R1";

  // reference model state
  logic [SY-1:0] mSync;
  logic          mEdge;
  logic [CW-1:0] mChan, mShadow;
  logic          mLvl, mFlag, mArm, mMax;
  logic [5:0]    mCtl;

  always #2.5 clk = ~clk;

  tmr_chan #(.CNT_W(CW), .SYNC_STAGES(SY)) u0 (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntOvf(cntOvf),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

  task automatic checkOne(string req, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] modelRead(logic a);
    logic [CW-1:0] r;
    r = '0;
    if (a) r = mChan;
    else begin
      r[7]   = mFlag;
      r[5:0] = mCtl;
    end
    return r;
  endfunction

  task automatic step();
    logic [1:0] ms, es;
    logic tov, mx, isP, isC, isO, rise, fall, capE, hit, maxN, nLvl, nFlag, nArm, nMax, nEdge;
    logic [CW-1:0] cv, nChan, nShadow;
    logic [5:0] nCtl;
    logic [SY-1:0] nSync;
    ms   = mCtl[5:4];
    es   = mCtl[3:2];
    tov  = mCtl[1];
    mx   = mCtl[0];
    isP  = (es == 2'b00);
    isC  = !isP && ms == 2'b00;
    isO  = !isP && ms != 2'b00;
    rise = mSync[SY-1] & ~mEdge;
    fall = ~mSync[SY-1] & mEdge;
    capE = isC && ((es == 2'b01 && rise) || (es == 2'b10 && fall) || (es == 2'b11 && (rise || fall)));
    cv   = (isO && ms[1]) ? mShadow : mChan;
    hit  = isO && (cntVal == cv);
    maxN = tov & mx & isO;
    nLvl = mLvl;
    if (isP) nLvl = ~ms[0];
    else if (isO) begin
      if (cntOvf && tov) nLvl = (mMax || maxN) ? 1'b1 : ~mLvl;
      else if (mMax) nLvl = 1'b1;
      else if (hit) begin
        case (es)
          2'b01:   nLvl = ~mLvl;
          2'b10:   nLvl = 1'b0;
          default: nLvl = 1'b1;
        endcase
      end
    end
    nChan   = capE ? cntVal : ((busWr && busAddr) ? busWrData : mChan);
    nShadow = cntOvf ? mChan : mShadow;
    nMax    = cntOvf ? maxN : mMax;
    nFlag   = (capE || hit) ? 1'b1 :
              ((busWr && !busAddr && mArm && !busWrData[7]) ? 1'b0 : mFlag);
    nArm    = (busWr && !busAddr) ? 1'b0 : ((busRd && !busAddr && mFlag) ? 1'b1 : mArm);
    nCtl    = (busWr && !busAddr) ? busWrData[5:0] : mCtl;
    nSync   = {mSync[SY-2:0], pinIn};
    nEdge   = mSync[SY-1];
    @(posedge clk); #1;
    mLvl = nLvl; mChan = nChan; mShadow = nShadow; mMax = nMax;
    mFlag = nFlag; mArm = nArm; mCtl = nCtl; mSync = nSync; mEdge = nEdge;
    cntVal = (cntVal == CW'(TOP)) ? '0 : cntVal + 1'b1;
    cntOvf = (cntVal == CW'(TOP));
    checkOne(curReq, "pinOut", CW'(pinOut), CW'(mLvl));
    checkOne(curReq, "pinOutEn", CW'(pinOutEn),
             CW'(mCtl[3:2] != 2'b00 && mCtl[5:4] != 2'b00));
    checkOne(curReq, "busRdData", busRdData, modelRead(busAddr));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic a, logic [CW-1:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    step();
    busWr = 1'b0;
  endtask

  task automatic rd(logic a);
    busRd = 1'b1; busAddr = a;
    step();
    busRd = 1'b0;
  endtask

  task automatic runToWrap();
    do step(); while (cntVal != '0);
  endtask

  task automatic periodLows(output int lows);
    lows = 0;
    do begin
      step();
      if (pinOut == 1'b0) lows++;
    end while (cntVal != '0);
  endtask

  task automatic clearFlag();
    rd(1'b0);
    wr(1'b0, {2'b00, mCtl});
  endtask

  initial begin
    int lowsA, lowsB, c;
    logic [CW-1:0] prevChan;
    rstN = 1'b0; cntVal = '0; cntOvf = 1'b0; busWr = 1'b0; busRd = 1'b0;
    busAddr = 1'b0; busWrData = '0; pinIn = 1'b0;
    mSync = '0; mEdge = 1'b0; mChan = '0; mShadow = '0; mLvl = 1'b1;
    mFlag = 1'b0; mArm = 1'b0; mMax = 1'b0; mCtl = '0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    curReq = "R1";
    checkOne("R1", "status", busRdData, '0);
    checkOne("R1", "pinOutEn", CW'(pinOutEn), '0);
    checkOne("R1", "pinOut", CW'(pinOut), CW'(1));
    busAddr = 1'b1; #1;
    checkOne("R1", "chan", busRdData, '0);
    run(3);

    // R2 register layout
    curReq = "R2";
    wr(1'b0, 8'hED);
    busAddr = 1'b0; #1;
    checkOne("R2", "status readback", busRdData, 8'h2D);
    wr(1'b1, 8'hA5);
    busAddr = 1'b1; #1;
    checkOne("R2", "chan readback", busRdData, 8'hA5);

    // R3 preset levels
    curReq = "R3";
    wr(1'b0, 8'h00); run(2);
    checkOne("R3", "preset high", CW'(pinOut), CW'(1));
    checkOne("R3", "undriven", CW'(pinOutEn), '0);
    wr(1'b0, 8'h10); run(2);
    checkOne("R3", "preset low", CW'(pinOut), '0);

    // R4 capture sweep, R5 flag clearing
    for (int es = 1; es < 4; es++) begin
      curReq = "R4";
      wr(1'b0, CW'(es << 2));
      run(4);
      clearFlag();
      for (int e = 0; e < 2; e++) begin
        busAddr = 1'b1; #1;
        prevChan = busRdData;
        c = int'(cntVal);
        pinIn = ~pinIn;
        run(4);
        busAddr = 1'b1; #1;
        if ((pinIn && es != 2) || (!pinIn && es != 1))
          checkOne("R4", "captured count", busRdData, CW'((c + 2) % (TOP + 1)));
        else
          checkOne("R4", "edge ignored", busRdData, prevChan);
        curReq = "R5";
        if ((pinIn && es != 2) || (!pinIn && es != 1)) begin
          wr(1'b0, CW'(es << 2));
          busAddr = 1'b0; #1;
          checkOne("R5", "unarmed clear ignored", CW'(busRdData[7]), CW'(1));
          clearFlag();
          busAddr = 1'b0; #1;
          checkOne("R5", "armed clear", CW'(busRdData[7]), '0);
        end
        curReq = "R4";
      end
    end
    pinIn = 1'b0;

    // R8 toggle-on-wrap has no effect in capture mode
    curReq = "R8";
    wr(1'b0, 8'h06); run(2);
    lowsA = int'(pinOut);
    runToWrap(); run(3); runToWrap(); run(3);
    checkOne("R8", "capture ignores wrap toggle", CW'(pinOut), CW'(lowsA));

    // R6 compare actions
    curReq = "R6";
    wr(1'b1, 8'd5);
    wr(1'b0, 8'h14); runToWrap();
    periodLows(lowsA); periodLows(lowsB);
    checkOne("R6", "toggle duty", CW'(lowsA + lowsB), CW'(TOP + 1));
    busAddr = 1'b0; #1;
    checkOne("R6", "match flag", CW'(busRdData[7]), CW'(1));
    wr(1'b0, 8'h18); runToWrap(); periodLows(lowsA);
    checkOne("R6", "clear on match", CW'(lowsA), CW'(TOP + 1));
    wr(1'b0, 8'h1C); runToWrap(); periodLows(lowsA);
    checkOne("R6", "set on match", CW'(lowsA), '0);

    // R8 PWM by clear-on-match plus wrap toggle
    curReq = "R8";
    wr(1'b1, 8'd8);
    wr(1'b0, 8'h1A); runToWrap(); runToWrap();
    periodLows(lowsA);
    checkOne("R8", "pwm low time", CW'(lowsA), CW'(TOP - 8));

    // R7 unbuffered vs buffered rewrite
    curReq = "R7";
    wr(1'b1, 8'd4); periodLows(lowsA);
    checkOne("R7", "unbuffered immediate", CW'(lowsA), CW'(TOP - 4));
    wr(1'b1, 8'd8);
    wr(1'b0, 8'h2A); runToWrap(); runToWrap();
    wr(1'b1, 8'd4); periodLows(lowsA);
    checkOne("R7", "buffered deferred", CW'(lowsA), CW'(TOP - 8));
    periodLows(lowsA);
    checkOne("R7", "buffered applied", CW'(lowsA), CW'(TOP - 4));

    // R9 wrap beats same-cycle match
    curReq = "R9";
    wr(1'b1, CW'(TOP));
    wr(1'b0, 8'h16); runToWrap();
    periodLows(lowsA); periodLows(lowsB);
    checkOne("R9", "single toggle per period", CW'(lowsA + lowsB), CW'(TOP + 1));

    // R10 full-duty latency
    curReq = "R10";
    wr(1'b1, 8'd8);
    wr(1'b0, 8'h1A); runToWrap(); runToWrap();
    wr(1'b0, 8'h1B); periodLows(lowsA);
    checkOne("R10", "set not yet active", CW'(lowsA), CW'(TOP - 8));
    periodLows(lowsA);
    checkOne("R10", "full duty", CW'(lowsA), '0);
    wr(1'b0, 8'h1A); periodLows(lowsA);
    checkOne("R10", "clear not yet active", CW'(lowsA), '0);
    periodLows(lowsA);
    checkOne("R10", "pwm resumes", CW'(lowsA), CW'(TOP - 8));

    // R11 full-duty request without wrap toggle
    curReq = "R11";
    wr(1'b0, 8'h19); runToWrap(); runToWrap();
    periodLows(lowsA);
    checkOne("R11", "no override", CW'(lowsA), CW'(TOP + 1));

    // sweep every mode/select/toggle combination against the model
    wr(1'b1, 8'd7);
    for (int ms = 0; ms < 4; ms++)
      for (int es = 0; es < 4; es++)
        for (int t = 0; t < 2; t++) begin
          curReq = (es == 0) ? "R3" : ((ms == 0) ? "R4" : "R6");
          wr(1'b0, CW'((ms << 4) | (es << 2) | (t << 1)));
          for (int k = 0; k < 4; k++) begin
            run(5);
            pinIn = ~pinIn;
          end
        end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule